// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Unit

This unit sits between the interrupt sources of a system and a processor core. It turns edges on a reset-request line and a non-maskable request line into pending flags. It records every change of a 6-bit maskable interrupt level. At each instruction boundary signalled by the core, it picks at most one pending item in fixed priority order and acts on it.

Reset and non-maskable requests both raise one shared exception pulse. The maskable path keeps the hardware-interrupt pending (IP) field of the cause register up to date. It raises an interrupt pulse only when the status register's global enable is set and the pending level shares a bit with the status mask. A level that is disabled or masked stays pending and is tried again at every later boundary. Writing zero to the level input acts as an end-of-interrupt: it discards any pending level and clears the IP field at the next evaluation.

Top module: `irq_deliver`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every pending item and the IP field. After reset, both exception outputs read 0 and `cause_ip_o` reads 0 until a new request arrives.
- R2: A rising edge on `rst_req_i` makes `rst_nmi_exc_o` pulse for exactly one cycle, at the next cycle in which `boundary_i` is high. Holding the input high does not raise another pulse.
- R3: A rising edge on `nmi_req_i` raises the same `rst_nmi_exc_o` pulse. When both a reset request and an NMI are pending, each is consumed separately, on two successive boundaries.
- R4: While a reset request or an NMI is pending, a boundary serves that request only. No interrupt pulse is raised and `cause_ip_o` does not change in that cycle or the next one.
- R5: When the maskable path is evaluated at a boundary with a nonzero pending level, `cause_ip_o` shows that level from the following cycle.
- R6: `irq_exc_o` pulses in the boundary cycle only when `ie_i` is 1 and (pending level AND `im_i`) is nonzero. The pending level is then dropped, so later boundaries raise no further pulse for it, and `cause_ip_o` keeps the level.
- R7: A pending level that is disabled or masked raises no pulse. It is evaluated again at every later boundary and is delivered at the first boundary where it is enabled and unmasked.
- R8: A change of `lvl_i` to 0 is an end-of-interrupt. It discards any pending level. At the next evaluation it clears `cause_ip_o` (visible one cycle later) and raises no exception.
- R9: A newer change of `lvl_i` replaces an older pending level that has not yet been evaluated.
- R10: No exception pulse is raised and `cause_ip_o` does not change in any cycle with `boundary_i` low. Pending items are held across such cycles.
- R11: A new request that arrives in the same cycle as an older request of the same kind is consumed is kept pending, and it is served at a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rst_req_i | input | 1 | Reset request, acted on at its rising edge |
| nmi_req_i | input | 1 | Non-maskable request, acted on at its rising edge |
| lvl_i | input | 6 | Maskable interrupt level; each change is an event, and a change to 0 is an end-of-interrupt |
| boundary_i | input | 1 | High for one cycle when an instruction completes |
| ie_i | input | 1 | Status register current interrupt enable |
| im_i | input | 6 | Status register interrupt mask field |
| rst_nmi_exc_o | output | 1 | Reset/NMI exception pulse |
| irq_exc_o | output | 1 | Maskable interrupt exception pulse |
| cause_ip_o | output | 6 | Cause register hardware-interrupt pending field |

## Verification
The assertions assume that `ie_i` and `im_i` carry the live status fields in every boundary cycle. They also assume that `boundary_i` is the only qualifier of evaluation, so any pulse or IP change outside a boundary cycle counts as an error. The stimulus changes inputs only shortly after a rising edge and holds them through the following edge. It drives reset synchronously and places every request edge or level change so that the expected boundary on which it is served is known exactly.

// File: rtl/irq_deliver.sv
module irq_deliver #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_req_i,
  input  logic             nmi_req_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             boundary_i,
  input  logic             ie_i,
  input  logic [LVL_W-1:0] im_i,
  output logic             rst_nmi_exc_o,
  output logic             irq_exc_o,
  output logic [LVL_W-1:0] cause_ip_o
);

  logic             rst_q, nmi_q;
  logic [LVL_W-1:0] lvl_q;
  logic             pend_rst, pend_nmi, lvl_vld, eoi;
  logic [LVL_W-1:0] lvl_r, ip_r;

  logic rst_ev, nmi_ev, lvl_ev;
  logic take_rst, take_nmi, eval_lvl, take_irq;

  assign rst_ev = rst_req_i & ~rst_q;
  assign nmi_ev = nmi_req_i & ~nmi_q;
  assign lvl_ev = (lvl_i != lvl_q);

  assign take_rst = boundary_i & pend_rst;
  assign take_nmi = boundary_i & ~pend_rst & pend_nmi;
  assign eval_lvl = boundary_i & ~pend_rst & ~pend_nmi & (lvl_vld | eoi);
  assign take_irq = eval_lvl & lvl_vld & ie_i & (|(lvl_r & im_i));

  assign rst_nmi_exc_o = take_rst | take_nmi;
  assign irq_exc_o     = take_irq;
  assign cause_ip_o    = ip_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_q    <= 1'b0;
      nmi_q    <= 1'b0;
      lvl_q    <= '0;
      pend_rst <= 1'b0;
      pend_nmi <= 1'b0;
      lvl_vld  <= 1'b0;
      eoi      <= 1'b0;
      lvl_r    <= '0;
      ip_r     <= '0;
    end else begin
      rst_q <= rst_req_i;
      nmi_q <= nmi_req_i;
      lvl_q <= lvl_i;

      if (rst_ev)        pend_rst <= 1'b1;
      else if (take_rst) pend_rst <= 1'b0;

      if (nmi_ev)        pend_nmi <= 1'b1;
      else if (take_nmi) pend_nmi <= 1'b0;

      if (eval_lvl)
        ip_r <= lvl_vld ? lvl_r : '0;

      if (lvl_ev) begin
        if (lvl_i == '0) begin
          eoi     <= 1'b1;
          lvl_vld <= 1'b0;
        end else begin
          eoi     <= 1'b0;
          lvl_vld <= 1'b1;
          lvl_r   <= lvl_i;
        end
      end else if (eval_lvl) begin
        eoi <= 1'b0;
        if (take_irq) lvl_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_deliver_chk.sv
module irq_deliver_chk #(
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             boundary_i,
  input logic             ie_i,
  input logic [LVL_W-1:0] im_i,
  input logic             rst_nmi_exc_o,
  input logic             irq_exc_o,
  input logic [LVL_W-1:0] cause_ip_o
);

  p_pulse_gated_r10: assert property (@(posedge clk) disable iff (rst)
    (rst_nmi_exc_o | irq_exc_o) |-> boundary_i);

  p_ip_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !boundary_i |=> $stable(cause_ip_o));

  p_one_kind_r4: assert property (@(posedge clk) disable iff (rst)
    !(rst_nmi_exc_o && irq_exc_o));

  p_ip_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    rst_nmi_exc_o |=> $stable(cause_ip_o));

  p_irq_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    irq_exc_o |-> ie_i);

  p_ip_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
    irq_exc_o |=> ((cause_ip_o & $past(im_i)) != '0));

endmodule

bind irq_deliver irq_deliver_chk #(.LVL_W(LVL_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .boundary_i    (boundary_i),
  .ie_i          (ie_i),
  .im_i          (im_i),
  .rst_nmi_exc_o (rst_nmi_exc_o),
  .irq_exc_o     (irq_exc_o),
  .cause_ip_o    (cause_ip_o)
);

// File: tb/irq_deliver_tb_top.sv
`timescale 1ns/1ps
module irq_deliver_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rr = 1'b0, nm = 1'b0, bd = 1'b0, ie = 1'b0;
  logic [5:0] lv = '0, im = '0;
  logic       rn_o, irq_o;
  logic [5:0] ip_o;

  always #2.5 clk = ~clk;

  irq_deliver #(.LVL_W(6)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .rst_req_i     (rr),
    .nmi_req_i     (nm),
    .lvl_i         (lv),
    .boundary_i    (bd),
    .ie_i          (ie),
    .im_i          (im),
    .rst_nmi_exc_o (rn_o),
    .irq_exc_o     (irq_o),
    .cause_ip_o    (ip_o)
  );

  typedef struct {
    logic       rn;
    logic       irq;
    logic [5:0] ip;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   vectors = 0;
  int   errors  = 0;
  bit   done    = 1'b0;

  task automatic step(input logic r_rst, input logic r_rr, input logic r_nm,
                      input logic [5:0] r_lv, input logic r_bd, input logic r_ie,
                      input logic [5:0] r_im, input logic e_rn, input logic e_irq,
                      input logic [5:0] e_ip, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    rst = r_rst; rr = r_rr; nm = r_nm; lv = r_lv; bd = r_bd; ie = r_ie; im = r_im;
    e.rn = e_rn; e.irq = e_irq; e.ip = e_ip; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      vectors++;
      if (rn_o !== cur.rn || irq_o !== cur.irq || ip_o !== cur.ip) begin
        errors++;
        $display("FAIL %s: got rn=%b irq=%b ip=%h, expected rn=%b irq=%b ip=%h",
                 cur.tag, rn_o, irq_o, ip_o, cur.rn, cur.irq, cur.ip);
      end
    end
  end

  initial begin
    //   rst rr nm lv    bd ie im     rn irq ip
    step(1, 0, 0, 6'h00, 0, 0, 6'h00, 0, 0, 6'h00, "R1 reset");
    step(1, 0, 0, 6'h00, 1, 0, 6'h00, 0, 0, 6'h00, "R1 reset");
    step(0, 1, 0, 6'h00, 0, 0, 6'h00, 0, 0, 6'h00, "R10 rst edge no boundary");
    step(0, 1, 0, 6'h00, 1, 0, 6'h00, 1, 0, 6'h00, "R2 reset pulse");
    step(0, 1, 0, 6'h00, 1, 0, 6'h00, 0, 0, 6'h00, "R2 held no retrigger");
    step(0, 0, 1, 6'h00, 0, 0, 6'h00, 0, 0, 6'h00, "R3 nmi edge");
    step(0, 1, 1, 6'h00, 0, 0, 6'h00, 0, 0, 6'h00, "R3 reset edge");
    step(0, 1, 1, 6'h00, 1, 0, 6'h00, 1, 0, 6'h00, "R3 first of two");
    step(0, 1, 1, 6'h00, 1, 0, 6'h00, 1, 0, 6'h00, "R3 second of two");
    step(0, 1, 1, 6'h00, 1, 0, 6'h00, 0, 0, 6'h00, "R3 none left");
    step(0, 0, 0, 6'h05, 0, 0, 6'h00, 0, 0, 6'h00, "R4 level arrives");
    step(0, 0, 1, 6'h05, 0, 0, 6'h00, 0, 0, 6'h00, "R4 nmi arrives");
    step(0, 0, 0, 6'h05, 1, 1, 6'h3f, 1, 0, 6'h00, "R4 nmi beats level");
    step(0, 0, 0, 6'h05, 1, 1, 6'h3f, 0, 1, 6'h00, "R6 irq taken");
    step(0, 0, 0, 6'h05, 0, 1, 6'h3f, 0, 0, 6'h05, "R5 ip shows level");
    step(0, 0, 0, 6'h05, 1, 1, 6'h3f, 0, 0, 6'h05, "R6 no repeat");
    step(0, 0, 0, 6'h12, 0, 0, 6'h00, 0, 0, 6'h05, "R7 new level");
    step(0, 0, 0, 6'h12, 1, 1, 6'h01, 0, 0, 6'h05, "R7 masked");
    step(0, 0, 0, 6'h12, 0, 1, 6'h01, 0, 0, 6'h12, "R5 ip masked level");
    step(0, 0, 0, 6'h12, 1, 0, 6'h3f, 0, 0, 6'h12, "R7 disabled");
    step(0, 0, 0, 6'h12, 1, 1, 6'h02, 0, 1, 6'h12, "R7 retried and taken");
    step(0, 0, 0, 6'h00, 0, 0, 6'h00, 0, 0, 6'h12, "R8 eoi write");
    step(0, 0, 0, 6'h00, 1, 1, 6'h3f, 0, 0, 6'h12, "R8 eoi no exception");
    step(0, 0, 0, 6'h00, 0, 0, 6'h00, 0, 0, 6'h00, "R8 ip cleared");
    step(0, 0, 0, 6'h04, 0, 0, 6'h00, 0, 0, 6'h00, "R9 older level");
    step(0, 0, 0, 6'h20, 0, 0, 6'h00, 0, 0, 6'h00, "R9 newer level");
    step(0, 0, 0, 6'h20, 1, 1, 6'h04, 0, 0, 6'h00, "R9 older replaced");
    step(0, 0, 0, 6'h20, 0, 0, 6'h00, 0, 0, 6'h20, "R9 ip newer");
    step(0, 0, 0, 6'h00, 0, 0, 6'h00, 0, 0, 6'h20, "R8 eoi over pending");
    step(0, 0, 0, 6'h00, 1, 1, 6'h3f, 0, 0, 6'h20, "R8 pending discarded");
    step(0, 0, 0, 6'h00, 1, 1, 6'h3f, 0, 0, 6'h00, "R8 ip cleared");
    step(0, 0, 0, 6'h08, 0, 1, 6'h3f, 0, 0, 6'h00, "R10 level no boundary");
    step(0, 0, 0, 6'h08, 0, 1, 6'h3f, 0, 0, 6'h00, "R10 held");
    step(0, 0, 0, 6'h08, 0, 1, 6'h3f, 0, 0, 6'h00, "R10 held");
    step(0, 0, 0, 6'h08, 0, 1, 6'h3f, 0, 0, 6'h00, "R10 held");
    step(0, 0, 0, 6'h08, 1, 1, 6'h3f, 0, 1, 6'h00, "R10 delivered at boundary");
    step(0, 0, 0, 6'h08, 0, 0, 6'h00, 0, 0, 6'h08, "R5 ip");
    step(0, 0, 1, 6'h08, 0, 0, 6'h00, 0, 0, 6'h08, "R11 nmi edge");
    step(0, 0, 0, 6'h08, 0, 0, 6'h00, 0, 0, 6'h08, "R11 nmi low");
    step(0, 0, 1, 6'h08, 1, 0, 6'h00, 1, 0, 6'h08, "R11 consume with new edge");
    step(0, 0, 1, 6'h08, 1, 0, 6'h00, 1, 0, 6'h08, "R11 new nmi kept");
    step(0, 0, 1, 6'h08, 1, 0, 6'h00, 0, 0, 6'h08, "R11 none left");
    step(0, 0, 0, 6'h01, 0, 0, 6'h00, 0, 0, 6'h08, "R11 level one");
    step(0, 0, 0, 6'h02, 1, 1, 6'h01, 0, 1, 6'h08, "R11 consume with new level");
    step(0, 0, 0, 6'h02, 1, 1, 6'h02, 0, 1, 6'h01, "R11 new level kept");
    step(0, 0, 0, 6'h02, 0, 0, 6'h00, 0, 0, 6'h02, "R5 ip newest");
    step(1, 0, 0, 6'h02, 0, 0, 6'h00, 0, 0, 6'h02, "R1 mid-run reset");
    step(0, 0, 0, 6'h00, 0, 0, 6'h00, 0, 0, 6'h00, "R1 ip cleared");
    step(0, 0, 0, 6'h00, 1, 1, 6'h3f, 0, 0, 6'h00, "R1 nothing pending");
    @(posedge clk);
    #1;
    bd = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule